// File: doc/BRIEF.md
# Tag-Snooping Reservation Station Scheduler

This block is a small pool of waiting slots placed in front of a single functional unit. Each accepted operation brings an opcode, a destination tag and two sources. A source arrives either as a finished value or as the tag of an earlier operation whose result is still being computed. Waiting slots watch one result bus that carries a valid bit, a tag and a value. When a pending source tag equals the tag on the bus, the slot copies the value into itself. It never reads a register file at dispatch time.

In every cycle a fixed-priority picker takes the lowest-numbered slot whose two sources are both present and sends it to the functional unit, provided the unit is idle. The slot is released in the same cycle. The functional unit is not pipelined and has a fixed latency. When it finishes, it puts the destination tag and the result on the result bus, and that bus wakes the slots that consume the result. Upstream logic supplies renamed tags. Tag value 0 marks a source that is already a value.

Top module: `rs_sched`

## Requirements
- R1: An accepted issue (issue_valid high while issue_ready is high at a clock edge) fills the lowest-numbered empty slot with the opcode, the destination tag and both sources. A source tag of 0 means that the accompanying value is used as is.
- R2: issue_ready is low exactly when every slot is occupied. An issue_valid presented while issue_ready is low is dropped and never produces a result.
- R3: A slot is dispatched only when both of its sources are present and the functional unit is idle. At most one slot is dispatched per cycle.
- R4: When several slots are ready, the lowest-numbered one is dispatched. A ready slot that was issued later may go ahead of an earlier slot that is still waiting on a tag.
- R5: A pending source whose tag equals the tag of a valid result-bus cycle N captures the bus value. The slot can be dispatched no earlier than cycle N+1, and it is dispatched in cycle N+1 if the unit is idle and no lower slot is ready.
- R6: A source that is issued in the same cycle as a matching result broadcast takes the bus value at issue and counts as present.
- R7: A slot becomes empty at the clock edge that ends its dispatch cycle.
- R8: The unit computes with the opcode encoding 0 = a+b, 1 = a-b, 2 = a^b, 3 = a&b, truncated to the data width. The result and the destination tag appear on the result bus exactly FU_LAT cycles after the dispatch cycle. The unit is busy in between and can accept the next dispatch in the broadcast cycle.
- R9: During and right after reset every slot is empty, issue_ready is high, and disp_valid and res_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Issue request |
| issue_ready | output | 1 | An empty slot exists |
| issue_op | input | 2 | Opcode (0 add, 1 sub, 2 xor, 3 and) |
| issue_dst_tag | input | TAG_W | Tag given to this operation's result |
| issue_a_tag | input | TAG_W | Producer tag of source a, 0 if value given |
| issue_a_val | input | DATA_W | Value of source a |
| issue_b_tag | input | TAG_W | Producer tag of source b, 0 if value given |
| issue_b_val | input | DATA_W | Value of source b |
| disp_valid | output | 1 | A slot is dispatched this cycle |
| disp_slot | output | $clog2(NUM_ENT) | Index of the dispatched slot |
| disp_tag | output | TAG_W | Destination tag of the dispatched slot |
| res_valid | output | 1 | Result bus carries a result |
| res_tag | output | TAG_W | Tag of the result |
| res_val | output | DATA_W | Result value |

## Verification
The assertions assume that the tags in flight are nonzero and distinct. They also assume that every waiting source tag names an operation that has been accepted and has not broadcast before the issue cycle, since a tag whose result has already gone by would leave its slot waiting forever. The bench draws tags from a small pool for each scenario and refers only to producers that are still pending or that are broadcasting in the issue cycle itself. It computes every expected result from the opcode encoding and the operand values it chose, following dependency chains through its own table of expected results.

// File: rtl/rs_pkg.sv
package rs_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_XOR = 2'd2,
    OP_AND = 2'd3
  } rs_op_e;

  // Unit arithmetic on a wide container; callers truncate to their width.
  function automatic logic [63:0] fu_result(rs_op_e op, logic [63:0] a, logic [63:0] b);
    case (op)
      OP_ADD:  return a + b;
      OP_SUB:  return a - b;
      OP_XOR:  return a ^ b;
      default: return a & b;
    endcase
  endfunction

endpackage

// File: rtl/rs_prio.sv
module rs_prio #(
  parameter int N = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req,
  output logic [N-1:0]     gnt,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    gnt = '0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
        idx    = IDX_W'(i);
      end
    end
  end

  assign any = |req;

  // R3: never more than one winner
  p_single_gnt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R4: no requester below the winner
  p_lowest_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt) |-> ((req & (gnt - 1'b1)) == '0));

  // R3: the winner was requesting
  p_gnt_in_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt & ~req) == '0));

endmodule

// File: rtl/rs_slot.sv
module rs_slot
  import rs_pkg::*;
#(
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   alloc_i,
  input  logic                   grant_i,
  input  rs_op_e                 op_i,
  input  logic [TAG_W-1:0]       dtag_i,
  input  logic [1:0][TAG_W-1:0]  stag_i,
  input  logic [1:0][DATA_W-1:0] sval_i,
  input  logic                   bc_valid_i,
  input  logic [TAG_W-1:0]       bc_tag_i,
  input  logic [DATA_W-1:0]      bc_val_i,
  output logic                   busy_o,
  output logic                   ready_o,
  output rs_op_e                 op_o,
  output logic [TAG_W-1:0]       dtag_o,
  output logic [1:0][DATA_W-1:0] opnd_o
);

  logic              busy_q;
  rs_op_e            op_q;
  logic [TAG_W-1:0]  dtag_q;
  logic              src_rdy [2];
  logic              hit_issue [2];
  logic              hit_wait [2];
  logic              wake_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      op_q   <= OP_ADD;
      dtag_q <= '0;
    end else if (alloc_i) begin
      busy_q <= 1'b1;
      op_q   <= op_i;
      dtag_q <= dtag_i;
    end else if (grant_i) begin
      busy_q <= 1'b0;
    end
  end

  for (genvar s = 0; s < 2; s++) begin : g_src
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] val_q;

    assign hit_issue[s] = bc_valid_i && (stag_i[s] != '0) && (stag_i[s] == bc_tag_i);
    assign hit_wait[s]  = busy_q && !src_rdy[s] && bc_valid_i && (tag_q == bc_tag_i);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        src_rdy[s] <= 1'b0;
        tag_q      <= '0;
        val_q      <= '0;
      end else if (alloc_i) begin
        tag_q <= stag_i[s];
        if (stag_i[s] == '0) begin
          src_rdy[s] <= 1'b1;
          val_q      <= sval_i[s];
        end else if (hit_issue[s]) begin
          src_rdy[s] <= 1'b1;
          val_q      <= bc_val_i;
        end else begin
          src_rdy[s] <= 1'b0;
        end
      end else if (hit_wait[s]) begin
        src_rdy[s] <= 1'b1;
        val_q      <= bc_val_i;
      end
    end

    assign opnd_o[s] = val_q;

    // R5: a snooped match leaves the source present next cycle
    p_wake_fills_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hit_wait[s] && !grant_i |=> src_rdy[s] && (val_q == $past(bc_val_i)));

    // R6: match on the issue cycle is taken at issue
    p_issue_catch_r6: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_i && hit_issue[s] |=> src_rdy[s] && (val_q == $past(bc_val_i)));
  end

  assign wake_evt = hit_wait[0] || hit_wait[1];
  assign busy_o   = busy_q;
  assign ready_o  = busy_q && src_rdy[0] && src_rdy[1];
  assign op_o     = op_q;
  assign dtag_o   = dtag_q;

  // R1: allocation only targets an empty slot
  p_alloc_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_i |-> !busy_q);

  // R7: a dispatched slot is empty afterwards
  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    grant_i |=> !busy_q);

  // R3: only complete slots are granted
  p_grant_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    grant_i |-> ready_o);

  // R5: a slot capturing now cannot be dispatched now
  p_wake_not_same_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |-> !grant_i);

endmodule

// File: rtl/rs_fu.sv
module rs_fu
  import rs_pkg::*;
#(
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16,
  parameter int FU_LAT = 3,
  localparam int CW    = $clog2(FU_LAT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_i,
  input  rs_op_e            op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [TAG_W-1:0]  tag_i,
  output logic              free_o,
  output logic              bc_valid_o,
  output logic [TAG_W-1:0]  bc_tag_o,
  output logic [DATA_W-1:0] bc_val_o
);

  logic [CW-1:0]     cnt_q;
  logic [DATA_W-1:0] res_q;
  logic [TAG_W-1:0]  tag_q;
  logic [DATA_W-1:0] calc;

  assign calc = DATA_W'(fu_result(op_i, 64'(a_i), 64'(b_i)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      res_q <= '0;
      tag_q <= '0;
    end else if (fire_i) begin
      cnt_q <= CW'(FU_LAT);
      res_q <= calc;
      tag_q <= tag_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign free_o     = (cnt_q <= CW'(1));
  assign bc_valid_o = (cnt_q == CW'(1));
  assign bc_tag_o   = tag_q;
  assign bc_val_o   = res_q;

  // R3: a dispatch never lands on a busy unit
  p_fire_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i |-> free_o);

  if (FU_LAT > 1) begin : g_quiet
    // R8: no result right after a dispatch when latency exceeds one
    p_quiet_after_fire_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fire_i |=> !bc_valid_o);
  end

endmodule

// File: rtl/rs_sched.sv
module rs_sched
  import rs_pkg::*;
#(
  parameter int NUM_ENT = 4,
  parameter int TAG_W   = 4,
  parameter int DATA_W  = 16,
  parameter int FU_LAT  = 3,
  localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  output logic              issue_ready,
  input  logic [1:0]        issue_op,
  input  logic [TAG_W-1:0]  issue_dst_tag,
  input  logic [TAG_W-1:0]  issue_a_tag,
  input  logic [DATA_W-1:0] issue_a_val,
  input  logic [TAG_W-1:0]  issue_b_tag,
  input  logic [DATA_W-1:0] issue_b_val,
  output logic              disp_valid,
  output logic [IDX_W-1:0]  disp_slot,
  output logic [TAG_W-1:0]  disp_tag,
  output logic              res_valid,
  output logic [TAG_W-1:0]  res_tag,
  output logic [DATA_W-1:0] res_val
);

  logic [NUM_ENT-1:0] busy_vec, ready_vec, free_vec;
  logic [NUM_ENT-1:0] alloc_gnt, alloc_vec, pick_gnt, grant_vec;
  logic               alloc_any, pick_any, fu_free, fire;
  logic [IDX_W-1:0]   alloc_idx, pick_idx;

  rs_op_e                 ent_op   [NUM_ENT];
  logic [TAG_W-1:0]       ent_dtag [NUM_ENT];
  logic [1:0][DATA_W-1:0] ent_opnd [NUM_ENT];

  logic [1:0][TAG_W-1:0]  in_tags;
  logic [1:0][DATA_W-1:0] in_vals;
  logic                   bc_valid;
  logic [TAG_W-1:0]       bc_tag;
  logic [DATA_W-1:0]      bc_val;

  assign in_tags  = {issue_b_tag, issue_a_tag};
  assign in_vals  = {issue_b_val, issue_a_val};
  assign free_vec = ~busy_vec;

  rs_prio #(.N(NUM_ENT)) u_alloc (
    .clk(clk), .rst_n(rst_n), .req(free_vec),
    .gnt(alloc_gnt), .any(alloc_any), .idx(alloc_idx)
  );

  assign issue_ready = alloc_any;
  assign alloc_vec   = alloc_gnt & {NUM_ENT{issue_valid}};

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_slot
    rs_slot #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .alloc_i(alloc_vec[i]), .grant_i(grant_vec[i]),
      .op_i(rs_op_e'(issue_op)), .dtag_i(issue_dst_tag),
      .stag_i(in_tags), .sval_i(in_vals),
      .bc_valid_i(bc_valid), .bc_tag_i(bc_tag), .bc_val_i(bc_val),
      .busy_o(busy_vec[i]), .ready_o(ready_vec[i]),
      .op_o(ent_op[i]), .dtag_o(ent_dtag[i]), .opnd_o(ent_opnd[i])
    );
  end

  rs_prio #(.N(NUM_ENT)) u_pick (
    .clk(clk), .rst_n(rst_n), .req(ready_vec),
    .gnt(pick_gnt), .any(pick_any), .idx(pick_idx)
  );

  assign fire      = pick_any && fu_free;
  assign grant_vec = pick_gnt & {NUM_ENT{fire}};

  rs_fu #(.TAG_W(TAG_W), .DATA_W(DATA_W), .FU_LAT(FU_LAT)) u_fu (
    .clk(clk), .rst_n(rst_n), .fire_i(fire),
    .op_i(ent_op[pick_idx]),
    .a_i(ent_opnd[pick_idx][0]), .b_i(ent_opnd[pick_idx][1]),
    .tag_i(ent_dtag[pick_idx]),
    .free_o(fu_free), .bc_valid_o(bc_valid), .bc_tag_o(bc_tag), .bc_val_o(bc_val)
  );

  assign disp_valid = fire;
  assign disp_slot  = pick_idx;
  assign disp_tag   = ent_dtag[pick_idx];
  assign res_valid  = bc_valid;
  assign res_tag    = bc_tag;
  assign res_val    = bc_val;

  // R2: a full pool accepts nothing
  p_stall_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_ready |-> (alloc_vec == '0));

  // R1: the chosen slot is occupied after an accepted issue
  p_alloc_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && issue_ready |=> busy_vec[$past(alloc_idx)]);

  // R3: the dispatched slot is ready
  p_disp_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> ready_vec[pick_idx]);

endmodule

// File: tb/rs_sched_tb.sv
module rs_sched_tb;

  localparam int CLK_P  = 10;
  localparam int N_ENT  = 4;
  localparam int TW     = 4;
  localparam int DW     = 8;
  localparam int LAT    = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          issue_valid;
  logic          issue_ready;
  logic [1:0]    issue_op;
  logic [TW-1:0] issue_dst_tag, issue_a_tag, issue_b_tag;
  logic [DW-1:0] issue_a_val, issue_b_val;
  logic          disp_valid;
  logic [1:0]    disp_slot;
  logic [TW-1:0] disp_tag;
  logic          res_valid;
  logic [TW-1:0] res_tag;
  logic [DW-1:0] res_val;

  rs_sched #(.NUM_ENT(N_ENT), .TAG_W(TW), .DATA_W(DW), .FU_LAT(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .issue_valid(issue_valid), .issue_ready(issue_ready), .issue_op(issue_op),
    .issue_dst_tag(issue_dst_tag), .issue_a_tag(issue_a_tag), .issue_a_val(issue_a_val),
    .issue_b_tag(issue_b_tag), .issue_b_val(issue_b_val),
    .disp_valid(disp_valid), .disp_slot(disp_slot), .disp_tag(disp_tag),
    .res_valid(res_valid), .res_tag(res_tag), .res_val(res_val)
  );

  always #(CLK_P / 2) clk = ~clk;

  int            cyc = 0;
  int            disp_at [16];
  int            slot_at [16];
  int            bc_at [16];
  logic [DW-1:0] bc_val_at [16];
  logic [DW-1:0] exp_val [16];
  int            nchk = 0;
  int            nerr = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Port monitor: records when each tag was dispatched and broadcast.
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin
        disp_at[i] = -1;
        slot_at[i] = -1;
        bc_at[i]   = -1;
        bc_val_at[i] = '0;
      end
    end else begin
      if (disp_valid) begin
        disp_at[disp_tag] = cyc;
        slot_at[disp_tag] = int'(disp_slot);
      end
      if (res_valid) begin
        bc_at[res_tag]     = cyc;
        bc_val_at[res_tag] = res_val;
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    if (cyc > 150000) begin
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", nchk + 1, nerr + 1);
      $finish;
    end
  end

  function automatic logic [DW-1:0] model(int op, logic [DW-1:0] a, logic [DW-1:0] b);
    logic [DW-1:0] r;
    if (op == 0)      r = DW'(int'(a) + int'(b));
    else if (op == 1) r = DW'(int'(a) - int'(b));
    else if (op == 2) r = a ^ b;
    else              r = a & b;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Called at a negedge; returns at the negedge after the accepting edge.
  task automatic issue(input int op, input int dt, input int at, input int av, input int bt, input int bv);
    logic [DW-1:0] ea, eb;
    while (!issue_ready) @(negedge clk);
    ea = (at != 0) ? exp_val[at] : DW'(av);
    eb = (bt != 0) ? exp_val[bt] : DW'(bv);
    exp_val[dt]   = model(op, ea, eb);
    issue_valid   = 1'b1;
    issue_op      = 2'(op);
    issue_dst_tag = TW'(dt);
    issue_a_tag   = TW'(at);
    issue_a_val   = DW'(av);
    issue_b_tag   = TW'(bt);
    issue_b_val   = DW'(bv);
    @(negedge clk);
    issue_valid = 1'b0;
  endtask

  task automatic wait_tag(input int dt, input int t0);
    int n = 0;
    while (bc_at[dt] < t0 && n < 400) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic check_res(input int dt, input int t0, input string req);
    wait_tag(dt, t0);
    chk(bc_at[dt] >= t0, req, "result seen for tag", dt, dt);
    chk(bc_val_at[dt] == exp_val[dt], req, "result value", int'(bc_val_at[dt]), int'(exp_val[dt]));
    chk(bc_at[dt] - disp_at[dt] == LAT, "R8", "dispatch to result latency", bc_at[dt] - disp_at[dt], LAT);
  endtask

  initial begin
    int t0;
    rst_n = 1'b0;
    issue_valid = 1'b0;
    issue_op = '0;
    issue_dst_tag = '0;
    issue_a_tag = '0;
    issue_b_tag = '0;
    issue_a_val = '0;
    issue_b_val = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(issue_ready == 1'b1, "R9", "issue_ready in reset", int'(issue_ready), 1);
    chk(disp_valid == 1'b0, "R9", "disp_valid in reset", int'(disp_valid), 0);
    chk(res_valid == 1'b0, "R9", "res_valid in reset", int'(res_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(issue_ready == 1'b1 && !disp_valid && !res_valid, "R9", "idle after reset", 0, 0);

    // R8 / R1: opcode sweep with value sources
    for (int op = 0; op < 4; op++) begin
      t0 = cyc;
      for (int k = 0; k < 8; k++)
        issue(op, k + 1, 0, (k * 37 + op * 11 + 200) % 256, 0, (k * 53 + 5) % 256);
      for (int k = 0; k < 8; k++) check_res(k + 1, t0, "R8");
    end
    repeat (4) @(negedge clk);

    // R2 / R4 / R1: fill the pool behind a two-level chain
    t0 = cyc;
    issue(0, 1, 0, 3, 0, 4);       // P = 7
    issue(1, 2, 1, 0, 0, 1);       // Q = P - 1
    issue(2, 3, 2, 0, 0, 8'h0F);   // R
    issue(3, 4, 2, 0, 0, 8'h3C);   // S
    issue(0, 5, 2, 0, 2, 0);       // T = Q + Q
    chk(issue_ready == 1'b0, "R2", "issue_ready with all slots busy", int'(issue_ready), 0);
    issue_valid = 1'b1;            // dropped request, tag 9
    issue_op = 2'd0;
    issue_dst_tag = 4'd9;
    issue_a_tag = '0;
    issue_b_tag = '0;
    issue_a_val = 8'd1;
    issue_b_val = 8'd1;
    @(negedge clk);
    issue_valid = 1'b0;
    for (int k = 1; k <= 5; k++) check_res(k, t0, "R5");
    repeat (6) @(negedge clk);
    chk(bc_at[9] < t0, "R2", "dropped issue produced result", bc_at[9], -1);
    chk(slot_at[3] == 0, "R1", "slot of R", slot_at[3], 0);
    chk(slot_at[4] == 2, "R1", "slot of S", slot_at[4], 2);
    chk(slot_at[5] == 3, "R1", "slot of T", slot_at[5], 3);
    chk(disp_at[3] < disp_at[4] && disp_at[4] < disp_at[5], "R4", "lowest ready slot first", disp_at[4], disp_at[5]);
    chk(disp_at[3] == bc_at[2] + 1, "R5", "wake to dispatch", disp_at[3], bc_at[2] + 1);
    chk(issue_ready == 1'b1, "R7", "slots released after drain", int'(issue_ready), 1);

    // R4: younger ready slot overtakes older waiting one
    t0 = cyc;
    issue(0, 10, 0, 20, 0, 22);
    issue(2, 11, 10, 0, 0, 8'h55);
    issue(1, 12, 0, 9, 0, 30);
    check_res(11, t0, "R4");
    check_res(12, t0, "R4");
    chk(disp_at[12] < disp_at[11], "R4", "younger dispatched first", disp_at[12], disp_at[11]);
    chk(disp_at[12] - disp_at[10] == LAT, "R8", "back-to-back at broadcast cycle", disp_at[12] - disp_at[10], LAT);
    repeat (4) @(negedge clk);

    // R5: exact next-cycle dispatch after wakeup
    t0 = cyc;
    issue(3, 13, 0, 8'hF0, 0, 8'h3C);
    issue(0, 14, 13, 0, 0, 8'h81);
    check_res(14, t0, "R5");
    chk(disp_at[14] == bc_at[13] + 1, "R5", "dispatch cycle after capture", disp_at[14], bc_at[13] + 1);
    repeat (4) @(negedge clk);

    // R6: issue in the broadcast cycle of the producer
    t0 = cyc;
    issue(0, 6, 0, 100, 0, 27);
    while (!(res_valid && res_tag == 4'd6)) @(negedge clk);
    issue(1, 7, 6, 0, 0, 200);
    check_res(7, t0, "R6");
    chk(disp_at[7] == bc_at[6] + 1, "R6", "dispatch after issue capture", disp_at[7], bc_at[6] + 1);
    repeat (4) @(negedge clk);

    // R3: both sources tagged
    t0 = cyc;
    issue(0, 1, 0, 250, 0, 10);
    issue(2, 2, 0, 8'hAA, 0, 8'h0F);
    issue(1, 3, 1, 0, 2, 0);
    check_res(3, t0, "R3");
    chk(disp_at[3] == bc_at[2] + 1, "R3", "waits for last source", disp_at[3], bc_at[2] + 1);
    chk(disp_at[2] == bc_at[1], "R3", "second dispatch at unit release", disp_at[2], bc_at[1]);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule